// File: doc/BRIEF.md
# RS-485 Transmit Direction Control

This block drives the direction pin of a half-duplex RS-485 transceiver. The pin can serve as either RTS or DTR. The pin goes to its active level as soon as the transmitter reports pending data. It stays active while characters are queued or being shifted out.

When the final stop bit has left the line, the pin is held active for a programmable number of bit times and is then released. This lets the far end of a long cable settle before the driver is turned off. The hold is counted in baud ticks from a separate baud generator, so the pin timing follows the line rate rather than the system clock. A polarity input selects whether "active" means high or low. An enable input forces the pin to its inactive level.

The UART shifter, the baud generator and the register file that holds the delay and the polarity are outside this block. The UART supplies a level meaning "data queued or in flight" and a one-cycle strobe at the end of each stop bit.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: After reset, the pin sits at its inactive level, which is high for polarity 0.
- R2: With the block enabled, the pin reaches its active level in the clock cycle that follows the first cycle in which the pending flag is sampled high.
- R3: With polarity 0, active is logic 0 and inactive is logic 1.
- R4: With polarity 1, active is logic 1 and inactive is logic 0.
- R5: Once active, the pin stays active while the pending flag is high. After the flag drops, the pin stays active until a stop-done strobe arrives with the flag low. Baud ticks have no effect during this period.
- R6: With a hold value N from 1 to 255, the pin stays active through the first N-1 baud ticks that follow the stop-done strobe. It goes inactive in the cycle after the Nth tick. A tick in the same cycle as the strobe is not counted.
- R7: With a hold value of 0, the pin goes inactive in the cycle after the stop-done strobe.
- R8: If the pending flag rises during a hold, the hold is abandoned and the pin stays active. The next stop-done strobe starts a fresh hold of the full programmed length.
- R9: While the enable input is low, the pin is at its inactive level for the selected polarity, whatever the other inputs do.
- R10: While the pin is inactive and the pending flag is low, baud ticks and stop-done strobes leave the pin inactive.
- R11: The hold value is captured on the stop-done strobe. Changing it during a hold does not change the length of that hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Direction control enable |
| pol | input | 1 | Active level of the pin (0: active low, 1: active high) |
| tx_pending | input | 1 | Transmit data queued or in flight |
| stop_done | input | 1 | One-cycle strobe at the end of each stop bit |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| hold_len | input | DLY_W | Hold after the last stop bit, in bit times |
| dir_pin | output | 1 | Transceiver direction pin |

## Verification
The assertions assume that polarity changes only while the block is disabled. They also assume that stop-done and tick strobes last a single cycle. The bench changes polarity only with the enable low and the pin idle, and it holds each strobe for exactly one clock. Random frames mix hold lengths, tick spacings and strobes that occur while the flag is still high. Directed cases cover a zero hold, a maximum hold, a tick that coincides with the strobe, a hold cancelled by new data, and a delay value rewritten during a hold.

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pol,
  input  logic             tx_pending,
  input  logic             stop_done,
  input  logic             bit_tick,
  input  logic [DLY_W-1:0] hold_len,
  output logic             dir_pin
);
  typedef enum logic [1:0] {S_IDLE, S_SEND, S_HOLD} st_t;

  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  st_t             st;
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (!en) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (tx_pending) st <= S_SEND;
        S_SEND: if (stop_done && !tx_pending) begin
          if (hold_len == '0) st <= S_IDLE;
          else begin
            st  <= S_HOLD;
            cnt <= hold_len;
          end
        end
        S_HOLD: if (tx_pending) begin
          st  <= S_SEND;
          cnt <= '0;
        end else if (bit_tick) begin
          if (cnt == ONE) st <= S_IDLE;
          cnt <= cnt - ONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign dir_pin = (st != S_IDLE) ? pol : ~pol;
endmodule

module rs485_dir_ctrl_chk #(
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             pol,
  input logic             tx_pending,
  input logic             stop_done,
  input logic             bit_tick,
  input logic [DLY_W-1:0] hold_len,
  input logic             dir_pin
);
  logic act;
  assign act = (dir_pin == pol);

  // R9
  dis_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !act);

  // R2
  rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && tx_pending |=> act);

  // R7
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && stop_done && !tx_pending && hold_len == '0 |=> !act);

  // R6
  no_early_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && act && !bit_tick && !stop_done |=> act);

  // R10
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act && !tx_pending |=> !act);

  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && act && tx_pending |=> act);
endmodule

bind rs485_dir_ctrl rs485_dir_ctrl_chk #(.DLY_W(DLY_W)) u_chk (.*);

// File: tb/tb_rs485_dir_ctrl.sv
module tb_rs485_dir_ctrl;
  logic clk = 0, rst_n = 0, en = 0, pol = 0;
  logic tx_pending = 0, stop_done = 0, bit_tick = 0;
  logic [7:0] hold_len = 0;
  logic dir_pin;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rs485_dir_ctrl dut (.*);

  function automatic logic exp_pin(bit active, bit p);
    return active ? p : ~p;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(bit active, string req);
    logic e;
    e = exp_pin(active, pol);
    total++;
    if (dir_pin !== e) begin
      bad++;
      $display("FAIL %s: dir_pin=%b expected=%b at %0t", req, dir_pin, e, $time);
    end
  endtask

  task automatic set_pol(bit p);
    en = 0; step(); chk(0, "R9");
    pol = p; step(); en = 1; step();
    chk(0, p ? "R4" : "R3");
  endtask

  task automatic hold_phase(int n, int gap, bit rewrite, bit tick_at_strobe);
    stop_done = 1; bit_tick = tick_at_strobe; hold_len = 8'(n);
    step();
    stop_done = 0; bit_tick = 0;
    if (n == 0) begin chk(0, "R7"); return; end
    for (int k = 1; k <= n; k++) begin
      for (int g = 0; g < gap; g++) begin step(); chk(1, "R6"); end
      bit_tick = 1; step(); bit_tick = 0;
      if (rewrite && k == 1) hold_len = (n > 2) ? 8'd1 : 8'd200;
      if (k < n) chk(1, rewrite ? "R11" : "R6");
      else chk(0, rewrite ? "R11" : "R6");
    end
  endtask

  task automatic frame(int n, int gap, bit rewrite, bit tick_at_strobe);
    tx_pending = 1; step();
    chk(1, "R2");
    chk(1, pol ? "R4" : "R3");
    for (int i = 0; i < 3; i++) begin
      stop_done = 1; bit_tick = 1; step(); stop_done = 0; bit_tick = 0;
      chk(1, "R5");
    end
    tx_pending = 0;
    for (int i = 0; i < 3; i++) begin
      bit_tick = 1; step(); bit_tick = 0; chk(1, "R5");
    end
    hold_phase(n, gap, rewrite, tick_at_strobe);
  endtask

  initial begin
    void'($urandom(32'h1234_abcd));
    #1 chk(0, "R1");
    repeat (3) step();
    chk(0, "R1");
    rst_n = 1; step(); chk(0, "R1");

    tx_pending = 1; step(); chk(0, "R9");
    tx_pending = 0; bit_tick = 1; stop_done = 1; step();
    bit_tick = 0; stop_done = 0; chk(0, "R9");
    en = 1; step();

    for (int i = 0; i < 4; i++) begin
      bit_tick = 1; stop_done = i[0]; step(); bit_tick = 0; stop_done = 0;
      chk(0, "R10");
    end

    frame(0, 0, 0, 0);
    frame(1, 0, 0, 1);
    frame(4, 2, 0, 1);
    frame(255, 0, 0, 0);
    frame(6, 1, 1, 0);
    frame(2, 1, 1, 0);

    set_pol(1);
    frame(0, 0, 0, 0);
    frame(5, 1, 0, 0);

    tx_pending = 1; step(); chk(1, "R8");
    tx_pending = 0; hold_len = 5; stop_done = 1; step(); stop_done = 0;
    for (int i = 0; i < 2; i++) begin bit_tick = 1; step(); bit_tick = 0; chk(1, "R8"); end
    tx_pending = 1; step(); chk(1, "R8");
    for (int i = 0; i < 6; i++) begin bit_tick = 1; step(); bit_tick = 0; chk(1, "R8"); end
    tx_pending = 0; step(); chk(1, "R8");
    hold_phase(5, 0, 0, 0);

    tx_pending = 1; step(); chk(1, "R4");
    en = 0; step(); chk(0, "R9");
    tx_pending = 0; step();
    set_pol(0);

    for (int f = 0; f < 40; f++) begin
      int n, gap;
      n = (f % 5 == 0) ? $urandom_range(100, 255) : $urandom_range(0, 12);
      gap = $urandom_range(0, 3);
      if (f == 20) set_pol(1);
      frame(n, gap, $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1);
      for (int i = 0; i < 2; i++) begin
        bit_tick = 1; step(); bit_tick = 0; chk(0, "R10");
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule